// File: doc/BRIEF.md
# Multi-Mode Byte Permute Unit

This block assembles a 32-bit word out of bytes taken from an eight-byte pool. The pool is two 32-bit operands: the low word supplies pool bytes 0 to 3 (byte 0 is its least significant byte), and the high word supplies pool bytes 4 to 7. When the high operand is absent, its four bytes read as zero. A 3-bit mode picks the pattern. In the indexed mode, each selector nibble names the source of one result byte. Six fixed patterns (forward extract, backward extract, single-byte replicate, left clamp, right clamp, half-word replicate) are steered only by the two lowest selector bits.

One crossbar serves every mode. A small index generator turns the mode and selector into one pool index per result byte, plus a force-zero flag. An optional output register (parameter `REG_OUT`) gives the datapath a pipeline stage. With the register present, a result appears one clock after a valid strobe.

Top module: `bperm_unit`

## Requirements
- R1: Mode 0 (indexed): result byte k is pool byte selector[4k+2:4k]. Bit 4k+3 of each nibble and selector bits 31:16 have no effect.
- R2: Mode 1 (forward extract): with s = selector[1:0], result byte k is pool byte k+s. For s=3 the bytes from 3 down to 0 are {6,5,4,3}.
- R3: Mode 2 (backward extract): result byte k is pool byte (s-k) mod 8. For s=0 the bytes from 3 down to 0 are {5,6,7,0}.
- R4: Mode 3 (byte replicate): all four result bytes equal pool byte s.
- R5: Mode 4 (left clamp): result byte k is pool byte max(k,s). For s=1 the bytes from 3 down to 0 are {3,2,1,1}.
- R6: Mode 5 (right clamp): result byte k is pool byte min(k,s). For s=2 the bytes from 3 down to 0 are {2,2,1,0}.
- R7: Mode 6 (half replicate): the bytes are {1,0,1,0} when selector[0]=0 and {3,2,3,2} when selector[0]=1. Selector bit 1 has no effect.
- R8: In modes 1 to 6, selector bits 31:2 have no effect on the result.
- R9: When hi_valid is 0, pool bytes 4 to 7 read as 0x00 whatever the value of hi.
- R10: Mode 7 is illegal. It gives result 0 and raises bad_mode. Modes 0 to 6 give bad_mode 0.
- R11: With REG_OUT=1, result and bad_mode update one clock after a cycle with in_valid high, and out_valid is high in exactly that cycle. In a cycle without the strobe, result and bad_mode hold their values and out_valid is low.
- R12: A synchronous active-high reset clears result, bad_mode and out_valid. Reset takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| lo | input | 32 | Low operand, pool bytes 0 to 3 |
| hi | input | 32 | High operand, pool bytes 4 to 7 |
| hi_valid | input | 1 | High operand present; when low, pool bytes 4 to 7 are zero |
| selector | input | 32 | Byte indices (mode 0) or pattern index in bits 1:0 |
| mode | input | 3 | Permute mode, 0 to 6 legal |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Permuted word |
| bad_mode | output | 1 | Illegal mode flag |

## Verification
Two of the block's functions can act in the same cycle. The first is the zeroing of a missing high operand. The second is a fixed pattern whose window reaches into pool bytes 4 to 7: forward extract with s of 1 to 3, backward extract with s of 0 to 2, or an indexed nibble of 4 to 7. The bench provokes this by driving hi with non-zero filler and hi_valid low across every such pattern. It judges each result byte against a table of pool indices in which bytes 4 to 7 are taken as zero. A second overlap is reset asserted together with a strobe. It is judged by requiring out_valid and result to read zero afterwards.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    localparam int BYTE_W = 8;
    localparam int POOL_N = 8;
    localparam int OUT_N  = 4;
    localparam int IDX_W  = $clog2(POOL_N);

    typedef enum logic [2:0] {
        PM_INDEX = 3'd0,
        PM_FWD   = 3'd1,
        PM_BWD   = 3'd2,
        PM_REP8  = 3'd3,
        PM_CLL   = 3'd4,
        PM_CLR   = 3'd5,
        PM_REP16 = 3'd6,
        PM_BAD   = 3'd7
    } pmode_e;

    typedef struct packed {
        logic             zero;
        logic [IDX_W-1:0] idx;
    } bsel_t;

    function automatic logic [IDX_W-1:0] idx_max(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [IDX_W-1:0] idx_min(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/bperm_idx_gen.sv
module bperm_idx_gen
    import bperm_pkg::*;
#(
    parameter int SEL_W = 32
) (
    input  logic [SEL_W-1:0] selector,
    input  logic [2:0]       mode,
    output bsel_t            bsel [OUT_N],
    output logic             illegal
);
    localparam int NIB_W = 4;

    pmode_e            pm;
    logic [IDX_W-1:0]  s3;
    logic [OUT_N-1:0]  nib_top_unused;
    logic              sel_hi_unused;

    assign pm            = pmode_e'(mode);
    assign s3            = IDX_W'(selector[1:0]);
    assign illegal       = (pm == PM_BAD);
    assign sel_hi_unused = ^selector[SEL_W-1:NIB_W*OUT_N];

    for (genvar k = 0; k < OUT_N; k++) begin : g_byte
        localparam logic [IDX_W-1:0] KI = IDX_W'(k);
        assign nib_top_unused[k] = selector[NIB_W*k+NIB_W-1];

        always_comb begin
            bsel[k].zero = 1'b0;
            bsel[k].idx  = '0;
            case (pm)
                PM_INDEX: bsel[k].idx = selector[NIB_W*k +: IDX_W];
                PM_FWD:   bsel[k].idx = KI + s3;
                PM_BWD:   bsel[k].idx = s3 - KI;
                PM_REP8:  bsel[k].idx = s3;
                PM_CLL:   bsel[k].idx = idx_max(KI, s3);
                PM_CLR:   bsel[k].idx = idx_min(KI, s3);
                PM_REP16: bsel[k].idx = {1'b0, selector[0], KI[0]};
                default:  bsel[k].zero = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/bperm_byte_mux.sv
module bperm_byte_mux
    import bperm_pkg::*;
(
    input  logic [POOL_N*BYTE_W-1:0] pool,
    input  bsel_t                    sel,
    output logic [BYTE_W-1:0]        dout
);
    always_comb begin
        if (sel.zero) dout = '0;
        else          dout = pool[BYTE_W*sel.idx +: BYTE_W];
    end
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
    import bperm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1,
    parameter int WORD_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic              hi_valid,
    input  logic [WORD_W-1:0] selector,
    input  logic [2:0]        mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              bad_mode
);
    localparam int POOL_W = POOL_N * BYTE_W;

    logic [POOL_W-1:0] pool;
    bsel_t             bsel [OUT_N];
    logic              illegal_c;
    logic [WORD_W-1:0] word_c;

    assign pool = {(hi_valid ? hi : '0), lo};

    bperm_idx_gen #(.SEL_W(WORD_W)) u_idx (
        .selector (selector),
        .mode     (mode),
        .bsel     (bsel),
        .illegal  (illegal_c)
    );

    for (genvar k = 0; k < OUT_N; k++) begin : g_mux
        bperm_byte_mux u_mux (
            .pool (pool),
            .sel  (bsel[k]),
            .dout (word_c[BYTE_W*k +: BYTE_W])
        );
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                result    <= '0;
                bad_mode  <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result   <= word_c;
                    bad_mode <= illegal_c;
                end
            end
        end
    end else begin : g_comb
        logic clk_unused;
        logic rst_unused;
        assign clk_unused = clk;
        assign rst_unused = rst;
        assign out_valid  = in_valid;
        assign result     = word_c;
        assign bad_mode   = illegal_c;
    end
endmodule

// File: rtl/bperm_chk.sv
module bperm_chk #(
    parameter bit REG_OUT = 1'b1,
    parameter int WORD_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        mode,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              bad_mode
);
    if (REG_OUT) begin : g_seq
        p_strobe_lat_r11: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        p_no_strobe_r11: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && $stable(result) && $stable(bad_mode)));
        p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 3'd7) |=> bad_mode);
        p_flag_clr_r10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode != 3'd7) |=> !bad_mode);
        p_rep8_r4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 3'd3) |=>
            (result[7:0] == result[15:8] && result[15:8] == result[23:16] && result[23:16] == result[31:24]));
        p_rep16_r7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && mode == 3'd6) |=> (result[15:0] == result[31:16]));
        p_reset_r12: assert property (@(posedge clk)
            rst |=> (!out_valid && result == '0 && !bad_mode));
    end
    p_bad_zero_r10: assert property (@(posedge clk) disable iff (rst)
        bad_mode |-> (result == '0));
endmodule

bind bperm_unit bperm_chk #(.REG_OUT(REG_OUT), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .out_valid (out_valid),
    .result    (result),
    .bad_mode  (bad_mode)
);

// File: tb/bperm_unit_bench.sv
module bperm_unit_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] lo = '0, hi = '0, selector = '0;
    logic        hi_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic        out_valid, bad_mode;
    logic [31:0] result;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    logic [32:0] q_exp [$];
    string       q_tag [$];
    logic [31:0] last_res = '0;
    logic        last_bad = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bperm_unit u_bperm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lo(lo), .hi(hi),
        .hi_valid(hi_valid), .selector(selector), .mode(mode),
        .out_valid(out_valid), .result(result), .bad_mode(bad_mode)
    );

    function automatic logic [11:0] pattern(input logic [2:0] m, input logic [1:0] s);
        case ({m, s})
            {3'd1, 2'd0}: return {3'd3, 3'd2, 3'd1, 3'd0};
            {3'd1, 2'd1}: return {3'd4, 3'd3, 3'd2, 3'd1};
            {3'd1, 2'd2}: return {3'd5, 3'd4, 3'd3, 3'd2};
            {3'd1, 2'd3}: return {3'd6, 3'd5, 3'd4, 3'd3};
            {3'd2, 2'd0}: return {3'd5, 3'd6, 3'd7, 3'd0};
            {3'd2, 2'd1}: return {3'd6, 3'd7, 3'd0, 3'd1};
            {3'd2, 2'd2}: return {3'd7, 3'd0, 3'd1, 3'd2};
            {3'd2, 2'd3}: return {3'd0, 3'd1, 3'd2, 3'd3};
            {3'd3, 2'd0}: return {3'd0, 3'd0, 3'd0, 3'd0};
            {3'd3, 2'd1}: return {3'd1, 3'd1, 3'd1, 3'd1};
            {3'd3, 2'd2}: return {3'd2, 3'd2, 3'd2, 3'd2};
            {3'd3, 2'd3}: return {3'd3, 3'd3, 3'd3, 3'd3};
            {3'd4, 2'd0}: return {3'd3, 3'd2, 3'd1, 3'd0};
            {3'd4, 2'd1}: return {3'd3, 3'd2, 3'd1, 3'd1};
            {3'd4, 2'd2}: return {3'd3, 3'd2, 3'd2, 3'd2};
            {3'd4, 2'd3}: return {3'd3, 3'd3, 3'd3, 3'd3};
            {3'd5, 2'd0}: return {3'd0, 3'd0, 3'd0, 3'd0};
            {3'd5, 2'd1}: return {3'd1, 3'd1, 3'd1, 3'd0};
            {3'd5, 2'd2}: return {3'd2, 3'd2, 3'd1, 3'd0};
            {3'd5, 2'd3}: return {3'd3, 3'd2, 3'd1, 3'd0};
            {3'd6, 2'd0}: return {3'd1, 3'd0, 3'd1, 3'd0};
            {3'd6, 2'd1}: return {3'd3, 3'd2, 3'd3, 3'd2};
            {3'd6, 2'd2}: return {3'd1, 3'd0, 3'd1, 3'd0};
            default:      return {3'd3, 3'd2, 3'd3, 3'd2};
        endcase
    endfunction

    // expected {bad_mode, result}
    function automatic logic [32:0] model(input logic [31:0] l, input logic [31:0] h,
                                          input logic hv, input logic [31:0] s, input logic [2:0] m);
        logic [7:0]  pool [8];
        logic [31:0] r;
        logic [11:0] lst;
        for (int i = 0; i < 4; i++) begin
            pool[i]   = l[8*i +: 8];
            pool[i+4] = hv ? h[8*i +: 8] : 8'h00;
        end
        if (m == 3'd7) return {1'b1, 32'h0};
        lst = pattern(m, s[1:0]);
        for (int k = 0; k < 4; k++) begin
            if (m == 3'd0) r[8*k +: 8] = pool[s[4*k +: 3]];
            else           r[8*k +: 8] = pool[lst[3*k +: 3]];
        end
        return {1'b0, r};
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic drive(input logic [31:0] l, input logic [31:0] h, input logic hv,
                         input logic [31:0] s, input logic [2:0] m, input string tag);
        @(negedge clk);
        lo = l; hi = h; hi_valid = hv; selector = s; mode = m; in_valid = 1'b1;
        q_exp.push_back(model(l, h, hv, s, m));
        q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: samples at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R11", {bad_mode, result}, 33'h0);
                end else begin
                    logic [32:0] e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check({bad_mode, result} === e, t, {bad_mode, result}, e);
                end
                last_res = result;
                last_bad = bad_mode;
            end else begin
                check(result === last_res && bad_mode === last_bad, "R11",
                      {bad_mode, result}, {last_bad, last_res});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && result === 32'h0 && bad_mode === 1'b0, "R12",
              {bad_mode, result}, 33'h0);
        rst = 1'b0;

        // every mode, every pattern index, both operand states
        for (int m = 0; m < 8; m++) begin
            for (int s = 0; s < 4; s++) begin
                drive(32'h4433_2211, 32'h8877_6655, 1'b1,
                      (m == 0) ? 32'h0000_7531 + 32'(s) : 32'(s), 3'(m), mode_tag(3'(m)));
                drive(32'hD4C3_B2A1, 32'hEEFF_1234, 1'b0,
                      (m == 0) ? 32'h0000_4567 : 32'(s), 3'(m), "R9");
            end
        end
        // R1: nibble top bits and selector[31:16] ignored
        drive(32'h0403_0201, 32'h0807_0605, 1'b1, 32'hFFFF_C8D9, 3'd0, "R1");
        drive(32'h0403_0201, 32'h0807_0605, 1'b1, 32'h0000_4051, 3'd0, "R1");
        // R8: upper selector bits ignored in fixed modes
        for (int m = 1; m < 7; m++) begin
            drive(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 32'hA5A5_5A5E, 3'(m), "R8");
        end
        // R7: selector bit 1 does not matter
        drive(32'hCAFE_BEEF, 32'h0, 1'b1, 32'h2, 3'd6, "R7");
        // R11: back-to-back strobes
        @(negedge clk);
        lo = 32'h1122_3344; hi = 32'h5566_7788; hi_valid = 1'b1; selector = 32'h1; mode = 3'd1;
        in_valid = 1'b1;
        q_exp.push_back(model(lo, hi, 1'b1, selector, 3'd1)); q_tag.push_back("R11");
        @(negedge clk);
        mode = 3'd2;
        q_exp.push_back(model(lo, hi, 1'b1, selector, 3'd2)); q_tag.push_back("R11");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset together with a strobe
        lo = 32'hFFFF_FFFF; mode = 3'd3; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b0 && result === 32'h0 && bad_mode === 1'b0, "R12",
              {bad_mode, result}, 33'h0);
        rst = 1'b0;
        last_res = '0; last_bad = 1'b0;
        repeat (2) @(negedge clk);
        check(q_exp.size() == 0, "R11", 33'(q_exp.size()), 33'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule